// File: doc/BRIEF.md
# Pulse-Gap Write Bit Encoder

This block produces the on/off envelope of a low-frequency reader field while a command word is written to a transponder with pulse-gap coding. A start request loads a data word and a bit count. The field is first held off for a long opening gap. Each bit is then sent as a field-on interval, whose length depends on the bit value, followed by a fixed field-off gap. When the last gap has elapsed, a one-cycle completion pulse is raised and the field stays off.

All durations are counted in pulses of a 1 µs enable tick, so the block runs from any system clock. The defaults follow a 125 kHz carrier with an 8 µs field clock. The opening gap is 50 field clocks (400 ticks). The inter-bit gap is 20 field clocks (160 ticks). A 0 keeps the field on for 18 field clocks (144 ticks), and a 1 keeps it on for 50 field clocks (400 ticks). Carrier generation, antenna driving and readback belong to other blocks.

Top module: `pgw_encoder`

## Requirements
- R1: After reset, `fieldOn`, `busy` and `done` are all 0.
- R2: A `startReq` seen in the idle state is accepted. `busy` is 1 from the next cycle, and the field then stays off for exactly START_GAP_TICKS ticks before the first bit (or before completion when no bits are sent).
- R3: A data bit of value 0 keeps `fieldOn` at 1 for exactly ZERO_ON_TICKS ticks.
- R4: A data bit of value 1 keeps `fieldOn` at 1 for exactly ONE_ON_TICKS ticks.
- R5: Every field-on interval, including the last one, is followed by a field-off gap of exactly WRITE_GAP_TICKS ticks.
- R6: With an effective count n, exactly n bits are sent, in the order `dataWord[n-1]`, `dataWord[n-2]`, … `dataWord[0]`. Bits of `dataWord` at index n and above are not used.
- R7: `done` is 1 for exactly one cycle, in the cycle after the tick that ends the final gap. `busy` is 0 in that same cycle, and `fieldOn` stays 0 until the next accepted start.
- R8: A `startReq` that arrives while `busy` is 1 is ignored. The sequence in progress continues unchanged.
- R9: A `bitCount` of 0 sends only the opening gap and then completes. A `bitCount` larger than MAX_BITS is treated as MAX_BITS.
- R10: Time advances only on `usTick`. While `usTick` is held at 0, `fieldOn` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle enable pulse, one per microsecond |
| startReq | input | 1 | Request to start a command; acted on only when idle |
| bitCount | input | $clog2(MAX_BITS+1) | Number of bits to send, sampled at start |
| dataWord | input | MAX_BITS | Command bits, right-aligned, sampled at start |
| fieldOn | output | 1 | Field enable envelope (1 = field on) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when the command has finished |

## Verification
The bench rebuilds the complete on/off envelope of each command by counting ticks in every interval. It compares the result with a sequence derived from the data word. A swapped bit order, an off-by-one in any phase length or a missing final gap therefore shows up as a wrong interval length or a wrong interval count. Commands with zero bits, one bit, the full 64 bits and an oversized count check the boundaries. An encoder that mishandles these would skip or add a bit, or read bits above the count. One command receives a second start request partway through, with the tick stopped for several cycles. A design that restarts, or that counts clock cycles instead of ticks, would distort the envelope or move the field while time should be frozen.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Phase of the write sequence; also used to select the active length.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_MARK  = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   load;     // capture word and count
    logic   restart;  // clear phase timer
    logic   advance;  // shift to next bit, decrement remaining
    phase_e sel;      // which duration the timer compares against
  } dpCtrl_t;

endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int START_GAP_TICKS = 400,
  parameter int WRITE_GAP_TICKS = 160,
  parameter int ZERO_ON_TICKS   = 144,
  parameter int ONE_ON_TICKS    = 400,
  parameter int MAX_BITS        = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           usTick,
  input  dpCtrl_t                        ctl,
  input  logic [$clog2(MAX_BITS+1)-1:0]  bitCount,
  input  logic [MAX_BITS-1:0]            dataWord,
  output logic                           expire,
  output logic                           bitsZero,
  output logic                           bitsOne,
  output logic                           curBit
);

  localparam int CNT_W   = $clog2(MAX_BITS + 1);
  localparam int MAX_A   = (START_GAP_TICKS > WRITE_GAP_TICKS) ? START_GAP_TICKS : WRITE_GAP_TICKS;
  localparam int MAX_B   = (ZERO_ON_TICKS > ONE_ON_TICKS) ? ZERO_ON_TICKS : ONE_ON_TICKS;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TIMER_W = $clog2(MAX_LEN + 1);

  logic [TIMER_W-1:0]  phaseTimer;
  logic [TIMER_W-1:0]  phaseLast;
  logic [CNT_W-1:0]    bitsLeft;
  logic [CNT_W-1:0]    loadCount;
  logic [CNT_W-1:0]    alignShift;
  logic [MAX_BITS-1:0] shiftReg;

  // Clamp oversized counts and left-align the used bits.
  always_comb begin
    if (bitCount > CNT_W'(MAX_BITS)) loadCount = CNT_W'(MAX_BITS);
    else                             loadCount = bitCount;
    alignShift = CNT_W'(MAX_BITS) - loadCount;
  end

  // Last timer value of the selected phase.
  always_comb begin
    unique case (ctl.sel)
      PH_START: phaseLast = TIMER_W'(START_GAP_TICKS - 1);
      PH_MARK:  phaseLast = curBit ? TIMER_W'(ONE_ON_TICKS - 1) : TIMER_W'(ZERO_ON_TICKS - 1);
      PH_GAP:   phaseLast = TIMER_W'(WRITE_GAP_TICKS - 1);
      default:  phaseLast = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseTimer <= '0;
    end else if (ctl.restart) begin
      phaseTimer <= '0;
    end else if (usTick) begin
      phaseTimer <= phaseTimer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else if (ctl.load) begin
      shiftReg <= dataWord << alignShift;
      bitsLeft <= loadCount;
    end else if (ctl.advance) begin
      shiftReg <= shiftReg << 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign expire   = usTick && (phaseTimer == phaseLast) && (ctl.sel != PH_IDLE);
  assign curBit   = shiftReg[MAX_BITS-1];
  assign bitsZero = (bitsLeft == '0);
  assign bitsOne  = (bitsLeft == CNT_W'(1));

endmodule

// File: rtl/pgw_control.sv
module pgw_control
  import pgw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    expire,
  input  logic    bitsZero,
  input  logic    bitsOne,
  output dpCtrl_t ctl,
  output logic    fieldOn,
  output logic    busy,
  output logic    done
);

  phase_e phase;
  phase_e phaseNext;
  logic   finishNow;

  always_comb begin
    phaseNext   = phase;
    finishNow   = 1'b0;
    ctl.load    = 1'b0;
    ctl.restart = 1'b0;
    ctl.advance = 1'b0;
    ctl.sel     = phase;
    unique case (phase)
      PH_IDLE: begin
        ctl.restart = 1'b1;
        if (startReq) begin
          ctl.load  = 1'b1;
          phaseNext = PH_START;
        end
      end
      PH_START: begin
        if (expire) begin
          ctl.restart = 1'b1;
          if (bitsZero) begin
            finishNow = 1'b1;
            phaseNext = PH_IDLE;
          end else begin
            phaseNext = PH_MARK;
          end
        end
      end
      PH_MARK: begin
        if (expire) begin
          ctl.restart = 1'b1;
          phaseNext   = PH_GAP;
        end
      end
      PH_GAP: begin
        if (expire) begin
          ctl.restart = 1'b1;
          ctl.advance = 1'b1;
          if (bitsOne) begin
            finishNow = 1'b1;
            phaseNext = PH_IDLE;
          end else begin
            phaseNext = PH_MARK;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= finishNow;
    end
  end

  assign fieldOn = (phase == PH_MARK);
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/pgw_encoder.sv
module pgw_encoder
  import pgw_pkg::*;
#(
  parameter int START_GAP_TICKS = 400,
  parameter int WRITE_GAP_TICKS = 160,
  parameter int ZERO_ON_TICKS   = 144,
  parameter int ONE_ON_TICKS    = 400,
  parameter int MAX_BITS        = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          usTick,
  input  logic                          startReq,
  input  logic [$clog2(MAX_BITS+1)-1:0] bitCount,
  input  logic [MAX_BITS-1:0]           dataWord,
  output logic                          fieldOn,
  output logic                          busy,
  output logic                          done
);

  dpCtrl_t dpCtl;
  logic    expire;
  logic    bitsZero;
  logic    bitsOne;
  logic    curBit;

  pgw_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .expire   (expire),
    .bitsZero (bitsZero),
    .bitsOne  (bitsOne),
    .ctl      (dpCtl),
    .fieldOn  (fieldOn),
    .busy     (busy),
    .done     (done)
  );

  pgw_datapath #(
    .START_GAP_TICKS (START_GAP_TICKS),
    .WRITE_GAP_TICKS (WRITE_GAP_TICKS),
    .ZERO_ON_TICKS   (ZERO_ON_TICKS),
    .ONE_ON_TICKS    (ONE_ON_TICKS),
    .MAX_BITS        (MAX_BITS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .ctl      (dpCtl),
    .bitCount (bitCount),
    .dataWord (dataWord),
    .expire   (expire),
    .bitsZero (bitsZero),
    .bitsOne  (bitsOne),
    .curBit   (curBit)
  );

endmodule

// File: rtl/pgw_encoder_chk.sv
module pgw_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic usTick,
  input logic startReq,
  input logic fieldOn,
  input logic busy,
  input logic done
);

  // R7
  field_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !fieldOn);

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy)));

  // R8
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy || done));

  // R10
  field_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(usTick) |-> $stable(fieldOn));

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

endmodule

bind pgw_encoder pgw_encoder_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .usTick   (usTick),
  .startReq (startReq),
  .fieldOn  (fieldOn),
  .busy     (busy),
  .done     (done)
);

// File: tb/pgw_encoder_bench.sv
module pgw_encoder_bench;

  localparam int ST  = 7;
  localparam int GP  = 3;
  localparam int Z0  = 2;
  localparam int O1  = 5;
  localparam int MB  = 64;
  localparam int CW  = $clog2(MB + 1);
  localparam int NV  = 8;

  localparam logic [CW-1:0] VEC_N [NV] = '{7'd1, 7'd8, 7'd64, 7'd0, 7'd100, 7'd16, 7'd5, 7'd33};
  localparam logic [MB-1:0] VEC_D [NV] = '{
    64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFA5, 64'hC3A5_0F1E_9B27_64D8,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_6B3C,
    64'hFFFF_FFFF_FFFF_FFF2, 64'hDEAD_BEEF_5555_AAAA};
  localparam bit VEC_P [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [CW-1:0] bitCount = '0;
  logic [MB-1:0] dataWord = '0;
  logic          fieldOn, busy, done;
  logic          usTick;
  logic [1:0]    tickDiv = '0;
  logic          tickHold = 1'b0;
  int            checks = 0;
  int            fails = 0;
  int            cycles = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= (tickDiv == 2'd2) ? 2'd0 : tickDiv + 2'd1;
    cycles  <= cycles + 1;
  end
  assign usTick = (tickDiv == 2'd0) && !tickHold;

  pgw_encoder #(
    .START_GAP_TICKS (ST),
    .WRITE_GAP_TICKS (GP),
    .ZERO_ON_TICKS   (Z0),
    .ONE_ON_TICKS    (O1),
    .MAX_BITS        (MB)
  ) u_pgw_encoder (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .startReq (startReq),
    .bitCount (bitCount),
    .dataWord (dataWord),
    .fieldOn  (fieldOn),
    .busy     (busy),
    .done     (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCmd(input int n, input logic [MB-1:0] d, input bit poke);
    int ivl [0:199];
    int k = 0;
    int cnt = 0;
    int guard = 0;
    int nEff;
    int holdCnt = 0;
    bit holding = 0;
    bit poked = 0;
    logic lvl = 1'b0;
    logic holdLvl = 1'b0;
    nEff = (n > MB) ? MB : n;
    @(negedge clk);
    bitCount = CW'(n);
    dataWord = d;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    while (guard < 20000) begin
      if (done) break;
      if (fieldOn !== lvl) begin
        ivl[k] = cnt;
        k++;
        cnt = 0;
        lvl = fieldOn;
      end
      if (holding) begin
        startReq = 1'b0;
        holdCnt++;
        if (holdCnt == 15) begin
          chk(fieldOn === holdLvl, "R10 field frozen without tick", int'(fieldOn), int'(holdLvl));
          chk(busy === 1'b1, "R8 still busy after ignored start", int'(busy), 1);
          tickHold = 1'b0;
          holding = 0;
        end
      end else if (poke && !poked && k == 3) begin
        poked = 1;
        holding = 1;
        holdCnt = 0;
        holdLvl = fieldOn;
        startReq = 1'b1;
        bitCount = CW'(2);
        dataWord = '0;
        tickHold = 1'b1;
      end
      if (busy && usTick) cnt++;
      @(negedge clk);
      guard++;
    end
    ivl[k] = cnt;
    k++;
    chk(k == 1 + 2 * nEff, "R6 R9 interval count", k, 1 + 2 * nEff);
    chk(ivl[0] == ST, "R2 start gap ticks", ivl[0], ST);
    for (int i = 1; i < k && i < 1 + 2 * nEff; i++) begin
      if (i % 2 == 1) begin
        if (d[nEff - 1 - (i - 1) / 2]) chk(ivl[i] == O1, "R4 R6 one-bit on time", ivl[i], O1);
        else                           chk(ivl[i] == Z0, "R3 R6 zero-bit on time", ivl[i], Z0);
      end else begin
        chk(ivl[i] == GP, "R5 write gap ticks", ivl[i], GP);
      end
    end
    chk(done === 1'b1 && busy === 1'b0, "R7 done with busy low", int'({done, busy}), 2);
    chk(fieldOn === 1'b0, "R7 field off at done", int'(fieldOn), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done lasts one cycle", int'(done), 0);
    chk(fieldOn === 1'b0, "R7 field stays off", int'(fieldOn), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(fieldOn === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset outputs",
        int'({fieldOn, busy, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(fieldOn === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle after reset",
        int'({fieldOn, busy, done}), 0);
    for (int v = 0; v < NV; v++) begin
      runCmd(int'(VEC_N[v]), VEC_D[v], VEC_P[v]);
    end
    // R9 explicit boundary: zero bits after a long command
    runCmd(0, 64'h1, 0);
    // R6 top bit only
    runCmd(64, 64'h8000_0000_0000_0000, 0);
    repeat (10) @(negedge clk);
    chk(fieldOn === 1'b0 && busy === 1'b0, "R7 idle holds field off", int'({fieldOn, busy}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule